// File: doc/BRIEF.md
# Trace Sample Word Packer

This block sits between a processor trace port and an on-chip trace buffer memory. Each clock cycle the port may present one sample. A sample is a 3-bit pipeline status, a packet field and a sync flag. The packet field is 4, 8 or 16 bits wide, depending on the configured port width. The packer concatenates samples into fixed 32-bit storage words. A word carries three, two or one sample depending on that width. When the last slot of a word is filled, the word goes out with a one-cycle valid strobe.

On a cycle marked as the trigger, the block writes a fixed trigger code into the status field. It keeps the true status in the low three bits of the packet field. A decoder that reads the buffer back can then recover both the trigger point and the real pipeline status.

A flush request forces out a partially filled word. The block reports when nothing is pending. Samples that arrive under an illegal port configuration are discarded.

Top module: `tp_word_packer`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1 and `word_valid` is 0.
- R2: With `port_width` = 2'b00 (4-bit packet), each sample takes an 8-bit slot: status in bits 2:0, packet in bits 6:3, sync in bit 7. Three samples make one word, in word bits 23:0.
- R3: With `port_width` = 2'b01 (8-bit packet), each sample takes a 12-bit slot: status in bits 2:0, packet in bits 10:3, sync in bit 11. Two samples make one word, in word bits 23:0.
- R4: With `port_width` = 2'b10 (16-bit packet), each word holds one sample: status in bits 2:0, packet in bits 18:3, sync in bit 19. The word is emitted in the cycle after the sample is accepted.
- R5: Slots fill from the least significant end upward, in arrival order. Cycles with `smp_valid` low leave the pending slots unchanged.
- R6: When `smp_trigger` is high with a sample, the status field holds the trigger code (parameter `TRIG_CODE`, default 3'b110). The packet field's low three bits hold the sample's true status. Its remaining packet bits come from `smp_packet`.
- R7: Word bits above the last used slot are always zero. For the 16-bit width, this means bits above 19. For the other widths, it means bits above 23.
- R8: `flush` emits the pending slots, including a sample accepted in the same cycle, as one word with the unfilled slots zero. `flush` with nothing pending emits nothing.
- R9: `empty` is low from the cycle after a sample is accepted until the cycle in which its word is presented. It rises in the cycle after that word's `word_valid` pulse.
- R10: `port_mode` encodes 2'b00 plain, 2'b01 demultiplexed, 2'b10 multiplexed and 2'b11 reserved. Demultiplexed mode is legal only with the 8-bit width. Multiplexed mode, reserved mode and `port_width` = 2'b11 are illegal. Samples offered under an illegal configuration are discarded.
- R11: `word_valid` is a single-cycle pulse. It appears only in the cycle after the edge that completed a word or flushed a partial one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_width | input | 2 | Packet width select: 00 4-bit, 01 8-bit, 10 16-bit, 11 illegal |
| port_mode | input | 2 | Port mode: 00 plain, 01 demultiplexed, 10 multiplexed, 11 reserved |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_status | input | 3 | Pipeline status of the sample |
| smp_packet | input | 16 | Packet bits; only the low 4/8/16 are used |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trigger | input | 1 | This sample is the trigger cycle |
| flush | input | 1 | Emit any pending partial word |
| word_valid | output | 1 | One-cycle strobe: `word_data` holds a new word |
| word_data | output | WORD_W | Packed storage word |
| empty | output | 1 | No slot pending and no word being presented |

## Verification
The hardest situations to reach are a flush and the sample that completes a word landing on the same edge, and a partial word left behind when a flush arrives. In those cases a stale slot or a double emission would show up. The bench sweeps every status value, with and without trigger and sync, for each width. It deliberately inserts idle gaps between samples. It ends each sweep with a flush that leaves one or two slots pending. Separate short sequences combine a flush with a sample in the same cycle. They also offer samples under each illegal width and mode combination and then flush, to prove those samples never reached the accumulator.

// File: rtl/tp_pack_pkg.sv
// Package: shared encodings and slot geometry for the trace word packer.
// Assumes packet widths double per width code starting at 4 bits.
package tp_pack_pkg;

    localparam int STAT_W       = 3;
    localparam int BASE_PKT_W   = 4;
    localparam int NUM_WIDTHS   = 3;
    localparam int MAX_PKT_W    = BASE_PKT_W << (NUM_WIDTHS - 1);
    localparam int MAX_SLOT_W   = STAT_W + MAX_PKT_W + 1;
    localparam int FILL_BITS    = 24;   // bits covered by the packed slots of the two narrow widths

    typedef enum logic [1:0] {
        PW_4   = 2'b00,
        PW_8   = 2'b01,
        PW_16  = 2'b10,
        PW_RSV = 2'b11
    } port_width_e;

    typedef enum logic [1:0] {
        PM_PLAIN = 2'b00,
        PM_DEMUX = 2'b01,
        PM_MUX   = 2'b10,
        PM_RSV   = 2'b11
    } port_mode_e;

    // Slot width in bits for a width code.
    function automatic int slot_width(port_width_e w);
        return STAT_W + (BASE_PKT_W << w) + 1;
    endfunction

    // Number of samples that make one word for a width code.
    function automatic logic [1:0] slots_per_word(port_width_e w);
        case (w)
            PW_4:    return 2'd3;
            PW_8:    return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/tp_cfg_check.sv
// Module: decides whether the width/mode pair is one the packer may capture in.
// Assumes the configuration is static while samples are pending.
module tp_cfg_check
    import tp_pack_pkg::*;
(
    input  logic [1:0] port_width,
    input  logic [1:0] port_mode,
    output logic       cfg_ok
);
    port_width_e w;
    port_mode_e  m;

    assign w = port_width_e'(port_width);
    assign m = port_mode_e'(port_mode);

    // Legality: plain mode at any real width, demultiplexed only at 8 bits.
    always_comb begin
        cfg_ok = 1'b0;
        if (w != PW_RSV) begin
            case (m)
                PM_PLAIN: cfg_ok = 1'b1;
                PM_DEMUX: cfg_ok = (w == PW_8);
                default:  cfg_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tp_slot_fmt.sv
// Module: formats one sample into a right-aligned slot {sync, packet, status}.
// On a trigger sample the status field carries TRIG_CODE and the true status
// moves into the low packet bits. Unused high slot bits are zero.
module tp_slot_fmt
    import tp_pack_pkg::*;
#(
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  logic [1:0]            port_width,
    input  logic [STAT_W-1:0]     status,
    input  logic [MAX_PKT_W-1:0]  packet,
    input  logic                  sync,
    input  logic                  trig,
    output logic [MAX_SLOT_W-1:0] slot
);
    logic [MAX_SLOT_W-1:0] cand [NUM_WIDTHS];
    logic [STAT_W-1:0]     stat_field;

    // Status field: trigger code replaces the status on trigger samples.
    assign stat_field = trig ? TRIG_CODE : status;

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        localparam int PW = BASE_PKT_W << g;
        logic [PW-1:0] pkt;

        // Packet field: true status relocated into the low bits on a trigger.
        always_comb begin
            pkt = packet[PW-1:0];
            if (trig) pkt[STAT_W-1:0] = status;
        end

        assign cand[g] = MAX_SLOT_W'({sync, pkt, stat_field});
    end

    // Width select: pick the candidate slot for the configured width.
    always_comb begin
        case (port_width)
            2'b00:   slot = cand[0];
            2'b01:   slot = cand[1];
            default: slot = cand[2];
        endcase
    end
endmodule

// File: rtl/tp_word_acc.sv
// Module: accumulates slots into a word, emits it when full or on flush.
// Assumes the width code does not change while slots are pending.
module tp_word_acc
    import tp_pack_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            port_width,
    input  logic                  take,
    input  logic [MAX_SLOT_W-1:0] slot,
    input  logic                  flush,
    output logic                  word_valid,
    output logic [WORD_W-1:0]     word_data,
    output logic                  empty
);
    localparam int SH_W = $clog2(WORD_W);

    port_width_e       w;
    logic [WORD_W-1:0] acc_q;
    logic [1:0]        cnt_q;
    logic [WORD_W-1:0] merged;
    logic [1:0]        cnt_nx;
    logic [SH_W-1:0]   shamt;
    logic              emit;

    assign w = port_width_e'(port_width);

    // Bit offset of the next free slot.
    assign shamt = SH_W'(int'(cnt_q) * slot_width(w));

    // Merge the incoming slot and decide whether a word leaves this cycle.
    always_comb begin
        merged = acc_q;
        cnt_nx = cnt_q;
        if (take) begin
            merged = acc_q | (WORD_W'(slot) << shamt);
            cnt_nx = cnt_q + 2'd1;
        end
        emit = (cnt_nx != 2'd0) && (flush || (cnt_nx >= slots_per_word(w)));
    end

    // Accumulator, slot count and output word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            cnt_q      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= emit;
            if (emit) begin
                word_data <= merged;
                acc_q     <= '0;
                cnt_q     <= '0;
            end else begin
                acc_q     <= merged;
                cnt_q     <= cnt_nx;
            end
        end
    end

    // Nothing pending: no slot held and no word currently presented.
    assign empty = (cnt_q == 2'd0) && !word_valid;
endmodule

// File: rtl/tp_word_packer.sv
// Top: packs per-cycle trace samples into storage words of WORD_W bits.
// Assumes WORD_W covers all packed slots; configuration is static while busy.
module tp_word_packer
    import tp_pack_pkg::*;
#(
    parameter int                WORD_W    = 32,
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           port_width,
    input  logic [1:0]           port_mode,
    input  logic                 smp_valid,
    input  logic [STAT_W-1:0]    smp_status,
    input  logic [MAX_PKT_W-1:0] smp_packet,
    input  logic                 smp_sync,
    input  logic                 smp_trigger,
    input  logic                 flush,
    output logic                 word_valid,
    output logic [WORD_W-1:0]    word_data,
    output logic                 empty
);
    logic                  cfg_ok;
    logic                  take;
    logic [MAX_SLOT_W-1:0] slot;

    initial begin
        if (WORD_W < FILL_BITS) $error("WORD_W too small for packed slots");
    end

    tp_cfg_check u_cfg (
        .port_width (port_width),
        .port_mode  (port_mode),
        .cfg_ok     (cfg_ok)
    );

    tp_slot_fmt #(.TRIG_CODE(TRIG_CODE)) u_fmt (
        .port_width (port_width),
        .status     (smp_status),
        .packet     (smp_packet),
        .sync       (smp_sync),
        .trig       (smp_trigger),
        .slot       (slot)
    );

    // Only samples under a legal configuration enter the accumulator.
    assign take = smp_valid && cfg_ok;

    tp_word_acc #(.WORD_W(WORD_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_width (port_width),
        .take       (take),
        .slot       (slot),
        .flush      (flush),
        .word_valid (word_valid),
        .word_data  (word_data),
        .empty      (empty)
    );
endmodule

// File: rtl/tp_word_packer_chk.sv
// Checker: port-level temporal properties of the trace word packer.
module tp_word_packer_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        port_width,
    input logic [1:0]        port_mode,
    input logic              smp_valid,
    input logic              flush,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              empty
);
    logic legal;

    // Independent port-level legality view for the properties.
    assign legal = (port_width != 2'b11) &&
                   ((port_mode == 2'b00) || (port_mode == 2'b01 && port_width == 2'b01));

    AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !flush) |=> !word_valid);                             // R11

    AST_ACCEPT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && legal) |=> !empty);                                     // R9

    AST_BAD_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !flush && smp_valid && !legal) |=> (empty && !word_valid)); // R10

    AST_WIDE_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && legal && port_width == 2'b10) |=> word_valid);          // R4

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_data[WORD_W-1:24] == '0));                       // R7

    AST_EMPTY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty) |-> $past(word_valid));                                  // R9
endmodule

bind tp_word_packer tp_word_packer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_width (port_width),
    .port_mode  (port_mode),
    .smp_valid  (smp_valid),
    .flush      (flush),
    .word_valid (word_valid),
    .word_data  (word_data),
    .empty      (empty)
);

// File: tb/tb_tp_word_packer.sv
module tb_tp_word_packer;
    localparam int   WORD_W = 32;
    localparam int   TRIG   = 6;     // default trigger code 3'b110

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  port_width = 2'b00;
    logic [1:0]  port_mode = 2'b00;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_status = '0;
    logic [15:0] smp_packet = '0;
    logic        smp_sync = 1'b0;
    logic        smp_trigger = 1'b0;
    logic        flush = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    // Expected word queue filled by the model, drained by the monitor.
    logic [31:0] exp_word [64];
    string       exp_tag  [64];
    int          wr_i = 0;
    int          rd_i = 0;
    logic [31:0] m_acc = '0;
    int          m_cnt = 0;
    bit          m_trig = 1'b0;

    tp_word_packer dut (
        .clk(clk), .rst_n(rst_n), .port_width(port_width), .port_mode(port_mode),
        .smp_valid(smp_valid), .smp_status(smp_status), .smp_packet(smp_packet),
        .smp_sync(smp_sync), .smp_trigger(smp_trigger), .flush(flush),
        .word_valid(word_valid), .word_data(word_data), .empty(empty)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: every word_valid must match the next expected word (R11, R7).
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (rd_i == wr_i) begin
                checks++; fails++;
                $display("FAIL R11: unexpected word 0x%08h expected none", word_data);
            end else begin
                check(exp_tag[rd_i % 64], word_data, exp_word[rd_i % 64]);
                check("R7", {24'h0, word_data[31:24]}, 32'h0);
                rd_i++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic bit legal_cfg();
        return (port_width != 2'b11) &&
               (port_mode == 2'b00 || (port_mode == 2'b01 && port_width == 2'b01));
    endfunction

    // Model step: optional sample, optional flush, computed from R2-R8.
    task automatic model(input bit v, input int st, input int pk, input bit sy,
                         input bit tr, input bit fl);
        int pw, sw, spw, s, p;
        logic [31:0] slot;
        pw  = 4 << port_width;
        sw  = pw + 4;
        spw = 24 / sw;
        if (v && legal_cfg()) begin
            p = pk & ((1 << pw) - 1);
            s = st;
            if (tr) begin p = (p & ~7) | st; s = TRIG; m_trig = 1'b1; end
            slot  = 32'(s + (p << 3) + (int'(sy) << (3 + pw)));
            m_acc = m_acc | (slot << (m_cnt * sw));
            m_cnt++;
        end
        if (m_cnt > 0 && (fl || m_cnt == spw)) begin
            exp_word[wr_i % 64] = m_acc;
            exp_tag[wr_i % 64]  = m_trig ? "R6" :
                                  (fl && m_cnt < spw) ? "R8" :
                                  (port_width == 2'b00) ? "R2" :
                                  (port_width == 2'b01) ? "R3" : "R4";
            wr_i++;
            m_acc = '0; m_cnt = 0; m_trig = 1'b0;
        end
    endtask

    task automatic drive(input bit v, input int st, input int pk, input bit sy,
                         input bit tr, input bit fl);
        @(negedge clk);
        smp_valid = v; smp_status = 3'(st); smp_packet = 16'(pk);
        smp_sync = sy; smp_trigger = tr; flush = fl;
        model(v, st, pk, sy, tr, fl);
        @(posedge clk);
        #1;
        smp_valid = 1'b0; flush = 1'b0; smp_trigger = 1'b0;
    endtask

    task automatic set_cfg(input int w, input int m);
        @(negedge clk);
        port_width = 2'(w); port_mode = 2'(m);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty", {31'h0, empty}, 32'h1);
        check("R1 word_valid", {31'h0, word_valid}, 32'h0);

        // R2 R3 R4 R5 R6: sweep status, trigger, sync per width with idle gaps.
        for (int w = 0; w < 3; w++) begin
            set_cfg(w, 0);
            for (int k = 0; k < 64; k++) begin
                drive(1'b1, k % 8, (k * 40503 + 4660) & 16'hffff, (k / 16) % 2 == 1,
                      (k / 8) % 2 == 1, 1'b0);
                if (k % 5 == 0) drive(1'b0, 0, 16'hffff, 1'b1, 1'b0, 1'b0); // R5 idle gap
            end
            drive(1'b1, 5, 16'h5a5a, 1'b1, 1'b0, 1'b0);
            drive(1'b0, 0, 0, 1'b0, 1'b0, 1'b1);                             // R8 leftover
        end

        // R3 R10: demultiplexed mode is legal at 8 bits.
        set_cfg(1, 1);
        for (int k = 0; k < 8; k++) drive(1'b1, k, k * 4369, k % 2 == 1, 1'b0, 1'b0);

        // R8 R9: partial flush in 4-bit mode, empty timing.
        set_cfg(0, 0);
        drive(1'b1, 3, 16'h000c, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 empty while pending", {31'h0, empty}, 32'h0);
        drive(1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 empty low during word", {31'h0, empty}, 32'h0);
        @(negedge clk);
        check("R9 empty rises after word", {31'h0, empty}, 32'h1);

        // R8: flush with a sample in the same cycle; flush while empty.
        drive(1'b1, 1, 16'h0002, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 7, 16'h000f, 1'b1, 1'b1, 1'b1);
        drive(1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 flush on empty", {31'h0, empty}, 32'h1);

        // R10: illegal configurations discard samples.
        for (int c = 0; c < 4; c++) begin
            case (c)
                0: set_cfg(0, 1);
                1: set_cfg(2, 1);
                2: set_cfg(1, 2);
                default: set_cfg(3, 0);
            endcase
            drive(1'b1, 2, 16'h1234, 1'b1, 1'b0, 1'b0);
            @(negedge clk);
            check("R10 sample ignored", {31'h0, empty}, 32'h1);
            set_cfg(0, 0);
            drive(1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
        end

        repeat (4) @(negedge clk);
        check("R11 all words seen", 32'(rd_i), 32'(wr_i));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule